// File: doc/BRIEF.md
# Operand Address Generator

This block sits between the instruction fetch path and the data-space port of a small 8-bit core whose data space is 256 bytes. Instruction bytes arrive one at a time with a valid strobe. Together with the first byte of each instruction, an external decoder supplies a 3-bit addressing-mode code. The block counts the bytes that mode needs. It keeps the opcode fields and the second byte it will use. Once the last byte has been taken, it publishes one registered result: the data-space address, whether that address is meaningful, whether the operand is a program byte instead, and the bit number and polarity for bit operations.

Short-direct operands map onto four fixed working registers at 80h to 83h. Indirect operands take their address from one of two pointer registers, whose current values are fed in from outside. Any number of idle cycles may separate the bytes of one instruction. The byte that follows a completed instruction is treated as a new opcode.

Top module: `opnd_addr_gen`

## Requirements
- R1: While `rst_n` is low, `op_vld` is 0 and the byte counter returns to idle. The first byte accepted after reset, or after a reset in the middle of an instruction, is decoded as an opcode.
- R2: The mode codes are 0 inherent/relative, 1 immediate, 2 direct, 3 short-direct, 4 indirect, 5 bit-direct, 6 bit-test-branch and 7 extended. Their instruction lengths are 1, 2, 2, 1, 1, 2, 3 and 2 bytes. `op_len` reports the length with the result.
- R3: `op_vld` is high for exactly the one cycle after the clock edge that accepts the last byte of an instruction, and low after earlier bytes. Two one-byte instructions on consecutive cycles give two consecutive strobes. The result outputs hold their value until the next strobe.
- R4: In direct mode, `op_addr` is the second instruction byte and `op_addr_vld` is 1.
- R5: In short-direct mode, `op_addr` is 80h plus opcode bits [1:0], so it is one of 80h, 81h, 82h or 83h.
- R6: In indirect mode, opcode bit 4 selects the pointer: 0 selects `ptr_x` and 1 selects `ptr_y`. `op_addr` is the selected pointer's value in the cycle the opcode is accepted.
- R7: In immediate mode, `op_prog` is 1 and `op_addr_vld` is 0.
- R8: In bit-direct mode, `op_addr` is the second byte, `op_bit_idx` is opcode bits [7:5], and `op_bit_set` is opcode bit 4 (1 = set, 0 = clear).
- R9: In bit-test-branch mode, the address and bit fields are formed as in R8. The third byte (the displacement) is consumed and has no effect on `op_addr`.
- R10: Inherent/relative and extended modes produce `op_addr_vld` = 0 and `op_prog` = 0.
- R11: `mode_i` is ignored on every byte except an opcode byte. Cycles with `instr_vld` low neither advance the sequence nor raise `op_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_vld | input | 1 | An instruction byte is offered and accepted this cycle |
| instr_byte | input | 8 | Instruction byte |
| mode_i | input | 3 | Addressing-mode code from the decoder, sampled with the opcode byte |
| ptr_x | input | 8 | Current value of pointer register X |
| ptr_y | input | 8 | Current value of pointer register Y |
| op_vld | output | 1 | One-cycle strobe that a new result is present |
| op_addr | output | 8 | Data-space operand address (0 when none) |
| op_addr_vld | output | 1 | `op_addr` names a data-space location |
| op_prog | output | 1 | Operand is the immediate program byte |
| op_bit_idx | output | 3 | Bit number for bit operations (0 otherwise) |
| op_bit_set | output | 1 | Bit polarity: 1 set, 0 clear (0 for other modes) |
| op_len | output | 2 | Instruction length in bytes of the result |

## Verification
Every result, and the `op_vld` strobe that marks it, appears one clock after the edge that accepts the last byte of its instruction. It never appears after an earlier byte, and it never appears during idle gaps. The bench drives inputs on the falling edge. Its send task samples `op_vld` at the falling edge after every non-final byte and after every gap cycle, where the strobe must be low. It samples all result outputs at the falling edge that follows the final byte, the first point where the registered result is visible. For the indirect pointer checks, the bench changes the pointer inputs right after the opcode edge. This confirms that the value captured is the one present in the opcode cycle.

// File: rtl/opnd_pkg.sv
// Package: shared types for the operand address generator.
// Assumes a 3-bit mode code from an external decoder; encodings are fixed.
package opnd_pkg;

    typedef enum logic [2:0] {
        M_INH  = 3'd0,   // inherent or relative branch
        M_IMM  = 3'd1,
        M_DIR  = 3'd2,
        M_SDIR = 3'd3,
        M_IND  = 3'd4,
        M_BITD = 3'd5,
        M_BTB  = 3'd6,
        M_EXT  = 3'd7
    } opnd_mode_e;

    // Opcode fields kept after the opcode byte has gone
    typedef struct packed {
        logic [1:0] reg_sel;   // short-direct register select
        logic       ptr_sel;   // indirect pointer select
        logic [2:0] bit_idx;   // bit number
        logic       bit_pol;   // set (1) or clear (0)
    } opnd_fields_t;

    // Instruction length in bytes for each mode (R2)
    function automatic logic [1:0] mode_len(opnd_mode_e m);
        case (m)
            M_IMM, M_DIR, M_BITD, M_EXT: mode_len = 2'd2;
            M_BTB:                       mode_len = 2'd3;
            default:                     mode_len = 2'd1;
        endcase
    endfunction

endpackage

// File: rtl/opnd_seq.sv
// Byte sequencer: counts accepted instruction bytes, holds the mode,
// the opcode fields and the second byte, and flags the last byte.
// Assumes mode_i is valid on the cycle the opcode byte is accepted.
module opnd_seq
    import opnd_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SDIR_LSB    = 0,
    parameter int PTR_SEL_BIT = 4,
    parameter int BIT_LSB     = 5,
    parameter int BIT_POL_BIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_vld,
    input  logic [BYTE_W-1:0] instr_byte,
    input  logic [2:0]        mode_i,
    output opnd_mode_e        eff_mode,
    output opnd_fields_t      eff_fld,
    output logic [BYTE_W-1:0] eff_b2,
    output logic [1:0]        eff_len,
    output logic              last
);

    logic [1:0]        cnt_q;
    opnd_mode_e        mode_q;
    opnd_fields_t      fld_q;
    logic [BYTE_W-1:0] b2_q;
    opnd_fields_t      fld_now;
    logic              first;

    // Extract the opcode fields from the incoming byte
    always_comb begin
        fld_now.reg_sel = instr_byte[SDIR_LSB +: 2];
        fld_now.ptr_sel = instr_byte[PTR_SEL_BIT];
        fld_now.bit_idx = instr_byte[BIT_LSB +: 3];
        fld_now.bit_pol = instr_byte[BIT_POL_BIT];
    end

    // Select live or held values depending on the byte position
    always_comb begin
        first    = (cnt_q == 2'd0);
        eff_mode = first ? opnd_mode_e'(mode_i) : mode_q;
        eff_fld  = first ? fld_now : fld_q;
        eff_b2   = (cnt_q == 2'd1) ? instr_byte : b2_q;
        eff_len  = mode_len(eff_mode);
        last     = instr_vld && ((cnt_q + 2'd1) == eff_len);
    end

    // Advance the byte counter and capture the mode, fields and second byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= 2'd0;
            mode_q <= M_INH;
            fld_q  <= '0;
            b2_q   <= '0;
        end else if (instr_vld) begin
            cnt_q <= last ? 2'd0 : cnt_q + 2'd1;
            if (first) begin
                mode_q <= eff_mode;
                fld_q  <= fld_now;
            end
            if (cnt_q == 2'd1) begin
                b2_q <= instr_byte;
            end
        end
    end

endmodule

// File: rtl/opnd_addr_mux.sv
// Address mux: forms the operand address and flags from the mode,
// the opcode fields, the second byte and the pointer registers.
// Pure combinational; assumes inputs are stable during the last-byte cycle.
module opnd_addr_mux
    import opnd_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  opnd_mode_e        mode,
    input  opnd_fields_t      fld,
    input  logic [ADDR_W-1:0] b2,
    input  logic [ADDR_W-1:0] ptr_x,
    input  logic [ADDR_W-1:0] ptr_y,
    output logic [ADDR_W-1:0] addr,
    output logic              addr_vld,
    output logic              prog,
    output logic [2:0]        bit_idx,
    output logic              bit_set
);

    localparam logic [ADDR_W-1:0] SDIR_BASE = ADDR_W'(1) << (ADDR_W - 1);

    // Choose the address source and flags for each mode
    always_comb begin
        addr     = '0;
        addr_vld = 1'b0;
        prog     = 1'b0;
        bit_idx  = 3'd0;
        bit_set  = 1'b0;
        case (mode)
            M_IMM:  prog = 1'b1;
            M_DIR: begin
                addr     = b2;
                addr_vld = 1'b1;
            end
            M_SDIR: begin
                addr     = SDIR_BASE | ADDR_W'(fld.reg_sel);
                addr_vld = 1'b1;
            end
            M_IND: begin
                addr     = fld.ptr_sel ? ptr_y : ptr_x;
                addr_vld = 1'b1;
            end
            M_BITD, M_BTB: begin
                addr     = b2;
                addr_vld = 1'b1;
                bit_idx  = fld.bit_idx;
                bit_set  = fld.bit_pol;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/opnd_addr_gen.sv
// Top: operand address generator for a 256-byte data space.
// Counts instruction bytes per mode and registers one result per
// instruction, strobed by op_vld one cycle after the last byte.
// Assumes the decoder presents mode_i alongside each opcode byte.
module opnd_addr_gen
    import opnd_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int SDIR_LSB    = 0,
    parameter int PTR_SEL_BIT = 4,
    parameter int BIT_LSB     = 5,
    parameter int BIT_POL_BIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_vld,
    input  logic [ADDR_W-1:0] instr_byte,
    input  logic [2:0]        mode_i,
    input  logic [ADDR_W-1:0] ptr_x,
    input  logic [ADDR_W-1:0] ptr_y,
    output logic              op_vld,
    output logic [ADDR_W-1:0] op_addr,
    output logic              op_addr_vld,
    output logic              op_prog,
    output logic [2:0]        op_bit_idx,
    output logic              op_bit_set,
    output logic [1:0]        op_len
);

    opnd_mode_e        eff_mode;
    opnd_fields_t      eff_fld;
    logic [ADDR_W-1:0] eff_b2;
    logic [1:0]        eff_len;
    logic              last;
    logic [ADDR_W-1:0] nxt_addr;
    logic              nxt_addr_vld;
    logic              nxt_prog;
    logic [2:0]        nxt_bit_idx;
    logic              nxt_bit_set;
    opnd_mode_e        res_mode_q;

    opnd_seq #(
        .BYTE_W      (ADDR_W),
        .SDIR_LSB    (SDIR_LSB),
        .PTR_SEL_BIT (PTR_SEL_BIT),
        .BIT_LSB     (BIT_LSB),
        .BIT_POL_BIT (BIT_POL_BIT)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .instr_vld  (instr_vld),
        .instr_byte (instr_byte),
        .mode_i     (mode_i),
        .eff_mode   (eff_mode),
        .eff_fld    (eff_fld),
        .eff_b2     (eff_b2),
        .eff_len    (eff_len),
        .last       (last)
    );

    opnd_addr_mux #(
        .ADDR_W (ADDR_W)
    ) u_mux (
        .mode     (eff_mode),
        .fld      (eff_fld),
        .b2       (eff_b2),
        .ptr_x    (ptr_x),
        .ptr_y    (ptr_y),
        .addr     (nxt_addr),
        .addr_vld (nxt_addr_vld),
        .prog     (nxt_prog),
        .bit_idx  (nxt_bit_idx),
        .bit_set  (nxt_bit_set)
    );

    // Register the result on the last byte and pulse the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_vld      <= 1'b0;
            op_addr     <= '0;
            op_addr_vld <= 1'b0;
            op_prog     <= 1'b0;
            op_bit_idx  <= 3'd0;
            op_bit_set  <= 1'b0;
            op_len      <= 2'd0;
            res_mode_q  <= M_INH;
        end else begin
            op_vld <= last;
            if (last) begin
                op_addr     <= nxt_addr;
                op_addr_vld <= nxt_addr_vld;
                op_prog     <= nxt_prog;
                op_bit_idx  <= nxt_bit_idx;
                op_bit_set  <= nxt_bit_set;
                op_len      <= eff_len;
                res_mode_q  <= eff_mode;
            end
        end
    end

endmodule

// File: rtl/opnd_addr_gen_chk.sv
// Checker: temporal properties of the operand address generator,
// attached to every instance of the top through bind.
module opnd_addr_gen_chk
    import opnd_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_vld,
    input logic              ptr_sel,
    input logic [ADDR_W-1:0] ptr_x,
    input logic [ADDR_W-1:0] ptr_y,
    input logic              op_vld,
    input logic [ADDR_W-1:0] op_addr,
    input logic              op_addr_vld,
    input logic              op_prog,
    input logic [1:0]        op_len,
    input opnd_mode_e        res_mode
);

    // R2: a result always carries a length of 1 to 3
    p_len_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        op_vld |-> (op_len != 2'd0));

    // R3 / R11: a strobe needs a byte accepted on the cycle before
    p_strobe_after_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
        op_vld |-> $past(instr_vld));

    // R11: an idle cycle never produces a strobe
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_vld |=> !op_vld);

    // R5: short-direct addresses stay within the four working registers
    p_sdir_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && res_mode == M_SDIR) |-> (op_addr[ADDR_W-1:2] == (ADDR_W-2)'(1) << (ADDR_W - 3)));

    // R6: an indirect address equals the pointer chosen in the opcode cycle
    p_ind_pointer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && res_mode == M_IND) |-> (op_addr == ($past(ptr_sel) ? $past(ptr_y) : $past(ptr_x))));

    // R7: an immediate operand never also names a data address
    p_imm_no_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && op_prog) |-> !op_addr_vld);

    // R10: modes without an operand report neither source
    p_no_operand_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && (res_mode == M_INH || res_mode == M_EXT)) |-> (!op_addr_vld && !op_prog));

endmodule

bind opnd_addr_gen opnd_addr_gen_chk #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_vld   (instr_vld),
    .ptr_sel     (instr_byte[PTR_SEL_BIT]),
    .ptr_x       (ptr_x),
    .ptr_y       (ptr_y),
    .op_vld      (op_vld),
    .op_addr     (op_addr),
    .op_addr_vld (op_addr_vld),
    .op_prog     (op_prog),
    .op_len      (op_len),
    .res_mode    (res_mode_q)
);

// File: tb/opnd_addr_gen_tb.sv
// Directed bench for the operand address generator: one task per scenario.
module opnd_addr_gen_tb;

    localparam logic [2:0] M_INH = 3'd0, M_IMM = 3'd1, M_DIR = 3'd2, M_SDIR = 3'd3,
                           M_IND = 3'd4, M_BITD = 3'd5, M_BTB = 3'd6, M_EXT = 3'd7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       instr_vld = 1'b0;
    logic [7:0] instr_byte = 8'h00;
    logic [2:0] mode_i = 3'd0;
    logic [7:0] ptr_x = 8'h00;
    logic [7:0] ptr_y = 8'h00;
    logic       op_vld;
    logic [7:0] op_addr;
    logic       op_addr_vld;
    logic       op_prog;
    logic [2:0] op_bit_idx;
    logic       op_bit_set;
    logic [1:0] op_len;

    int n_chk = 0;
    int n_err = 0;
    logic early;

    always #5 clk = ~clk;

    opnd_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .instr_vld(instr_vld), .instr_byte(instr_byte),
        .mode_i(mode_i), .ptr_x(ptr_x), .ptr_y(ptr_y), .op_vld(op_vld),
        .op_addr(op_addr), .op_addr_vld(op_addr_vld), .op_prog(op_prog),
        .op_bit_idx(op_bit_idx), .op_bit_set(op_bit_set), .op_len(op_len)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Feed n bytes; mode only meaningful on the opcode, scrambled afterwards.
    // Returns at the falling edge after the last byte, with instr_vld low.
    task automatic send(input logic [2:0] m, input logic [7:0] b0, input logic [7:0] b1,
                        input logic [7:0] b2, input int n, input int gap);
        early = 1'b0;
        for (int i = 0; i < n; i++) begin
            instr_vld  = 1'b1;
            instr_byte = (i == 0) ? b0 : (i == 1) ? b1 : b2;
            mode_i     = (i == 0) ? m : ~m;
            @(negedge clk);
            if (i != n - 1) begin
                if (op_vld) early = 1'b1;
                for (int g = 0; g < gap; g++) begin
                    instr_vld = 1'b0;
                    mode_i    = 3'd3;
                    @(negedge clk);
                    if (op_vld) early = 1'b1;
                end
            end
        end
        instr_vld = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "op_vld in reset", 32'(op_vld), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "op_vld after reset", 32'(op_vld), 32'd0);
    endtask

    task automatic t_direct();
        send(M_DIR, 8'h3A, 8'h5C, 8'h00, 2, 0);
        chk("R3", "no early strobe direct", 32'(early), 32'd0);
        chk("R3", "strobe direct", 32'(op_vld), 32'd1);
        chk("R4", "direct addr", 32'(op_addr), 32'h5C);
        chk("R4", "direct addr_vld", 32'(op_addr_vld), 32'd1);
        chk("R2", "direct len", 32'(op_len), 32'd2);
        @(negedge clk);
        chk("R3", "single-cycle strobe", 32'(op_vld), 32'd0);
        chk("R3", "result held", 32'(op_addr), 32'h5C);
    endtask

    task automatic t_short();
        for (int s = 0; s < 4; s++) begin
            send(M_SDIR, 8'hE4 | 8'(s), 8'h00, 8'h00, 1, 0);
            chk("R3", "back-to-back strobe", 32'(op_vld), 32'd1);
            chk("R5", "short-direct addr", 32'(op_addr), 32'h80 + 32'(s));
            chk("R2", "short-direct len", 32'(op_len), 32'd1);
        end
    endtask

    task automatic t_indirect();
        ptr_x = 8'h11;
        ptr_y = 8'h22;
        instr_vld = 1'b1; instr_byte = 8'h07; mode_i = M_IND;
        @(negedge clk);
        instr_vld = 1'b0; ptr_x = 8'h99;
        chk("R6", "indirect X", 32'(op_addr), 32'h11);
        chk("R2", "indirect len", 32'(op_len), 32'd1);
        ptr_x = 8'h11;
        instr_vld = 1'b1; instr_byte = 8'h17; mode_i = M_IND;
        @(negedge clk);
        instr_vld = 1'b0; ptr_y = 8'h77;
        chk("R6", "indirect Y", 32'(op_addr), 32'h22);
        chk("R6", "indirect addr_vld", 32'(op_addr_vld), 32'd1);
        @(negedge clk);
    endtask

    task automatic t_imm();
        send(M_IMM, 8'h15, 8'hA7, 8'h00, 2, 0);
        chk("R7", "imm prog", 32'(op_prog), 32'd1);
        chk("R7", "imm addr_vld", 32'(op_addr_vld), 32'd0);
        chk("R2", "imm len", 32'(op_len), 32'd2);
    endtask

    task automatic t_bitd();
        send(M_BITD, 8'b1011_0000, 8'hC3, 8'h00, 2, 0);
        chk("R8", "bitd addr", 32'(op_addr), 32'hC3);
        chk("R8", "bitd idx", 32'(op_bit_idx), 32'd5);
        chk("R8", "bitd set", 32'(op_bit_set), 32'd1);
        send(M_BITD, 8'b0100_1111, 8'h04, 8'h00, 2, 0);
        chk("R8", "bitd idx 2", 32'(op_bit_idx), 32'd2);
        chk("R8", "bitd clear", 32'(op_bit_set), 32'd0);
    endtask

    task automatic t_btb();
        send(M_BTB, 8'b1111_0000, 8'h6E, 8'hF1, 3, 0);
        chk("R9", "btb no early strobe", 32'(early), 32'd0);
        chk("R9", "btb strobe", 32'(op_vld), 32'd1);
        chk("R9", "btb addr", 32'(op_addr), 32'h6E);
        chk("R9", "btb idx", 32'(op_bit_idx), 32'd7);
        chk("R9", "btb pol", 32'(op_bit_set), 32'd1);
        chk("R2", "btb len", 32'(op_len), 32'd3);
    endtask

    task automatic t_noaddr();
        send(M_INH, 8'hFF, 8'h00, 8'h00, 1, 0);
        chk("R10", "inh addr_vld", 32'(op_addr_vld), 32'd0);
        chk("R10", "inh prog", 32'(op_prog), 32'd0);
        chk("R2", "inh len", 32'(op_len), 32'd1);
        send(M_EXT, 8'h29, 8'h40, 8'h00, 2, 0);
        chk("R10", "ext strobe", 32'(op_vld), 32'd1);
        chk("R10", "ext addr_vld", 32'(op_addr_vld), 32'd0);
        chk("R2", "ext len", 32'(op_len), 32'd2);
    endtask

    task automatic t_gap_mode();
        send(M_DIR, 8'h00, 8'h3D, 8'h00, 2, 3);
        chk("R11", "no strobe in gap", 32'(early), 32'd0);
        chk("R11", "gap strobe", 32'(op_vld), 32'd1);
        chk("R11", "gap addr", 32'(op_addr), 32'h3D);
        chk("R11", "mode ignored len", 32'(op_len), 32'd2);
        send(M_BTB, 8'h20, 8'h55, 8'h66, 3, 2);
        chk("R11", "gapped btb addr", 32'(op_addr), 32'h55);
        chk("R11", "gapped btb early", 32'(early), 32'd0);
    endtask

    task automatic t_reset_mid();
        instr_vld = 1'b1; instr_byte = 8'h12; mode_i = M_BTB;
        @(negedge clk);
        instr_vld = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "op_vld in mid reset", 32'(op_vld), 32'd0);
        rst_n = 1'b1;
        send(M_SDIR, 8'h02, 8'h00, 8'h00, 1, 0);
        chk("R1", "opcode after reset", 32'(op_vld), 32'd1);
        chk("R1", "addr after reset", 32'(op_addr), 32'h82);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_direct();
        t_short();
        t_indirect();
        t_imm();
        t_bitd();
        t_btb();
        t_noaddr();
        t_gap_mode();
        t_reset_mid();
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule